// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block pairs a direct-mapped line store with a small fully associative buffer that keeps lines recently pushed out of that store. Each CPU lookup presents a line address. The main set and every buffer entry are probed in the same cycle. A hit in the main store answers on the next cycle. If the main store misses but the buffer holds the line, the two structures exchange lines: the requested line moves into its main set, and the line that sat there takes over the freed buffer entry. The lookup then completes as a hit, with no traffic to the next level.

When both structures miss, the block raises a request to the next level and waits for the fill. The fill is written into the main set. The line it displaces, if valid, goes into the buffer, either into an empty entry or over the least recently written one. The block is blocking: a stall output holds off new lookups while an exchange or a miss is in progress. Lines are read-only here, so the block has no write-back and no coherence handling.

Top module: `victim_assist_cache`

## Requirements
- R1: After reset, every line in both structures is invalid. Stall, response valid and request valid are low, and the first lookup of any address misses.
- R2: A lookup accepted at a clock edge (lookup valid high and stall low) that matches the valid line in its main set gives response valid, hit = 1 and that line's data at the next edge. Stall stays low.
- R3: A lookup that misses the main set but matches a valid buffer entry keeps stall high for the two cycles after acceptance. It then gives response valid with hit = 1 and the line's data at the second edge after acceptance. No next-level request is raised.
- R4: After such an exchange, the requested line sits in its main set, so a repeated lookup hits per R2. The line previously in that set sits in the buffer, so a lookup of it is served per R3.
- R5: A lookup that misses both structures raises request valid at the next edge, with the request line equal to the lookup's full line address. Both stay steady, and stall stays high, until a fill is taken.
- R6: A fill (fill valid high while a request is pending) is written to the main set. At that same edge it gives response valid with hit = 0 and the fill data, and it drops the request. If the displaced main line was valid, that line enters the buffer.
- R7: A line entering the buffer takes the lowest-numbered invalid entry. If no entry is invalid, it takes the entry written least recently. Every buffer write, including the write during an exchange, makes that entry the most recent.
- R8: Lookup valid is ignored while stall is high, and fill valid is ignored while no request is pending. Neither produces a response or a request.
- R9: Matching compares the full line address (set bits and tag bits). A different tag in the same set is a miss even when the set is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request strobe |
| lk_line | input | LA_W | Line address of the lookup; the low IDX_W bits select the main set |
| lk_stall | output | 1 | High while an exchange or a miss is in progress; lookups are not accepted |
| rsp_valid | output | 1 | One-cycle pulse marking a completed lookup |
| rsp_hit | output | 1 | 1 if served by the main store or an exchange, 0 if served by a fill |
| rsp_data | output | DATA_W | Data of the requested line |
| req_valid | output | 1 | Pending request to the next level |
| req_line | output | LA_W | Line address being requested |
| fill_valid | input | 1 | Next level returns the requested line |
| fill_data | input | DATA_W | Data of the returned line |

## Verification
The hardest state to reach from the ports is a full buffer whose recency order differs from its insertion order. Reaching it needs a series of conflict misses on one set to fill every entry, followed by an exchange that refreshes one entry in the middle of the order. The stimulus starts with directed conflict sequences on a single set, so that a particular entry is known to be the oldest when the next miss arrives. It then runs a long random stream over a few sets and a handful of tags, which keeps the buffer full and causes frequent exchanges. A behavioural reference using per-entry write stamps predicts every outcome and its timing.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWAP1 = 2'd1,
    ST_SWAP2 = 2'd2,
    ST_MWAIT = 2'd3
  } vc_state_e;
endpackage

// File: rtl/vc_main_array.sv
module vc_main_array #(
  parameter int LA_W   = 16,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_set,
  output logic              rd_valid,
  output logic [LA_W-1:0]   rd_line,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_set,
  input  logic [LA_W-1:0]   wr_line,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   vld;
  logic [LA_W-1:0]   lines [SETS];
  logic [DATA_W-1:0] datas [SETS];

  assign rd_valid = vld[rd_set];
  assign rd_line  = lines[rd_set];
  assign rd_data  = datas[rd_set];

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (wr_en) vld[wr_set] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      lines[wr_set] <= wr_line;
      datas[wr_set] <= wr_data;
    end
  end
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int LA_W    = 16,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 4,
  parameter int EW      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LA_W-1:0]    look_line,
  output logic [ENTRIES-1:0] hit_vec,
  output logic               hit_any,
  output logic [EW-1:0]      hit_slot,
  output logic [DATA_W-1:0]  hit_data,
  output logic [EW-1:0]      repl_slot,
  input  logic               wr_en,
  input  logic [EW-1:0]      wr_slot,
  input  logic               wr_valid,
  input  logic [LA_W-1:0]    wr_line,
  input  logic [DATA_W-1:0]  wr_data
);
  localparam logic [EW-1:0] OLDEST = EW'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [LA_W-1:0]    lines [ENTRIES];
  logic [DATA_W-1:0]  datas [ENTRIES];
  logic [EW-1:0]      age   [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit_vec[g] = vld[g] && (lines[g] == look_line);
  end
  assign hit_any = |hit_vec;

  always_comb begin
    hit_slot = '0;
    hit_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        hit_slot = EW'(i);
        hit_data = datas[i];
      end
    end
  end

  // empty entry first (lowest index), otherwise the oldest by age
  always_comb begin
    logic found;
    found     = 1'b0;
    repl_slot = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!vld[i] && !found) begin
        repl_slot = EW'(i);
        found     = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (age[i] == OLDEST) repl_slot = EW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      for (int i = 0; i < ENTRIES; i++) age[i] <= EW'(i);
    end else if (wr_en) begin
      vld[wr_slot] <= wr_valid;
      for (int i = 0; i < ENTRIES; i++) begin
        if (EW'(i) == wr_slot)          age[i] <= '0;
        else if (age[i] < age[wr_slot]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      lines[wr_slot] <= wr_line;
      datas[wr_slot] <= wr_data;
    end
  end
endmodule

// File: rtl/victim_assist_cache.sv
module victim_assist_cache
  import vc_pkg::*;
#(
  parameter int LA_W   = 16,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32,
  parameter int VICT_N = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [LA_W-1:0]   lk_line,
  output logic              lk_stall,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              req_valid,
  output logic [LA_W-1:0]   req_line,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int EW = (VICT_N > 1) ? $clog2(VICT_N) : 1;

  function automatic logic [IDX_W-1:0] line_set(input logic [LA_W-1:0] l);
    return l[IDX_W-1:0];
  endfunction

  vc_state_e         state;
  logic [LA_W-1:0]   cur_line;
  logic [EW-1:0]     swap_slot;
  logic [LA_W-1:0]   look_line;

  logic              m_rd_valid;
  logic [LA_W-1:0]   m_rd_line;
  logic [DATA_W-1:0] m_rd_data;
  logic              m_wr_en;
  logic [DATA_W-1:0] m_wr_data;

  logic [VICT_N-1:0] vic_hit_vec;
  logic              v_hit_any;
  logic [EW-1:0]     v_hit_slot;
  logic [DATA_W-1:0] v_hit_data;
  logic [EW-1:0]     v_repl_slot;
  logic              v_wr_en;
  logic [EW-1:0]     v_wr_slot;
  logic              v_wr_valid;

  // named internal events
  logic acc, main_hit, swap_start, miss_start, in_swap1, fill_take;

  assign look_line  = (state == ST_IDLE) ? lk_line : cur_line;
  assign acc        = lk_valid && (state == ST_IDLE);
  assign main_hit   = m_rd_valid && (m_rd_line == look_line);
  assign swap_start = acc && !main_hit && v_hit_any;
  assign miss_start = acc && !main_hit && !v_hit_any;
  assign in_swap1   = (state == ST_SWAP1);
  assign fill_take  = (state == ST_MWAIT) && fill_valid;
  assign lk_stall   = (state != ST_IDLE);

  assign m_wr_en    = in_swap1 || fill_take;
  assign m_wr_data  = in_swap1 ? v_hit_data : fill_data;
  assign v_wr_en    = in_swap1 || (fill_take && m_rd_valid);
  assign v_wr_slot  = in_swap1 ? swap_slot : v_repl_slot;
  assign v_wr_valid = in_swap1 ? m_rd_valid : 1'b1;

  vc_main_array #(.LA_W(LA_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_main (
    .clk     (clk),
    .rst     (rst),
    .rd_set  (line_set(look_line)),
    .rd_valid(m_rd_valid),
    .rd_line (m_rd_line),
    .rd_data (m_rd_data),
    .wr_en   (m_wr_en),
    .wr_set  (line_set(cur_line)),
    .wr_line (cur_line),
    .wr_data (m_wr_data)
  );

  vc_victim_buf #(.LA_W(LA_W), .DATA_W(DATA_W), .ENTRIES(VICT_N), .EW(EW)) u_vict (
    .clk      (clk),
    .rst      (rst),
    .look_line(look_line),
    .hit_vec  (vic_hit_vec),
    .hit_any  (v_hit_any),
    .hit_slot (v_hit_slot),
    .hit_data (v_hit_data),
    .repl_slot(v_repl_slot),
    .wr_en    (v_wr_en),
    .wr_slot  (v_wr_slot),
    .wr_valid (v_wr_valid),
    .wr_line  (m_rd_line),
    .wr_data  (m_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_line  <= '0;
      swap_slot <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
      req_valid <= 1'b0;
      req_line  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (acc) begin
            cur_line <= lk_line;
            if (main_hit) begin
              rsp_valid <= 1'b1;
              rsp_hit   <= 1'b1;
              rsp_data  <= m_rd_data;
            end else if (v_hit_any) begin
              swap_slot <= v_hit_slot;
              state     <= ST_SWAP1;
            end else begin
              req_valid <= 1'b1;
              req_line  <= lk_line;
              state     <= ST_MWAIT;
            end
          end
        end
        ST_SWAP1: state <= ST_SWAP2;
        ST_SWAP2: begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b1;
          rsp_data  <= m_rd_data;
          state     <= ST_IDLE;
        end
        ST_MWAIT: begin
          if (fill_valid) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_data  <= fill_data;
            req_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int LA_W    = 16,
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_stall,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               req_valid,
  input logic [LA_W-1:0]    req_line,
  input logic               fill_valid,
  input logic               swap_start,
  input logic               miss_start,
  input logic               fill_take,
  input logic [ENTRIES-1:0] vic_hit_vec
);
  // R3
  swap_two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    swap_start |=> (lk_stall && !rsp_valid) ##1 lk_stall ##1 (rsp_valid && rsp_hit && !lk_stall));

  // R5
  req_raise_chk: assert property (@(posedge clk) disable iff (rst)
    miss_start |=> (req_valid && lk_stall));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !fill_valid) |=> (req_valid && $stable(req_line)));

  // R6
  fill_reply_chk: assert property (@(posedge clk) disable iff (rst)
    fill_take |=> (rsp_valid && !rsp_hit && !req_valid));

  // R9
  vic_unique_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vic_hit_vec));

  // R2
  rsp_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !lk_stall);
endmodule

bind victim_assist_cache vc_checker #(.LA_W(LA_W), .ENTRIES(VICT_N)) u_vc_checker (
  .clk        (clk),
  .rst        (rst),
  .lk_stall   (lk_stall),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .req_valid  (req_valid),
  .req_line   (req_line),
  .fill_valid (fill_valid),
  .swap_start (swap_start),
  .miss_start (miss_start),
  .fill_take  (fill_take),
  .vic_hit_vec(vic_hit_vec)
);

// File: tb/victim_assist_cache_bench.sv
module victim_assist_cache_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid;
  logic [15:0] lk_line;
  logic        lk_stall;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_data;
  logic        req_valid;
  logic [15:0] req_line;
  logic        fill_valid;
  logic [31:0] fill_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  victim_assist_cache u_victim_assist_cache (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_line(lk_line),
    .lk_stall(lk_stall), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_data(rsp_data), .req_valid(req_valid), .req_line(req_line),
    .fill_valid(fill_valid), .fill_data(fill_data)
  );

  // reference state: main sets, buffer entries with write stamps
  bit          m_v [8];
  logic [15:0] m_l [8];
  bit          v_v [4];
  logic [15:0] v_l [4];
  int          v_st [4];
  int          stamp = 0;

  function automatic logic [31:0] dfn(input logic [15:0] l);
    return {l, l ^ 16'hA5C3};
  endfunction

  function automatic int find_vic(input logic [15:0] l);
    for (int i = 0; i < 4; i++) if (v_v[i] && v_l[i] == l) return i;
    return -1;
  endfunction

  function automatic int pick_slot();
    int best = -1;
    for (int i = 0; i < 4; i++) if (!v_v[i]) return i;
    for (int i = 0; i < 4; i++) if (best < 0 || v_st[i] < v_st[best]) best = i;
    return best;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [15:0] line, input string lbl);
    int s = int'(line[2:0]);
    int e;
    int p;
    logic [31:0] exp = dfn(line);
    lk_valid = 1'b1;
    lk_line  = line;
    @(negedge clk);
    lk_valid = 1'b0;
    if (m_v[s] && m_l[s] == line) begin
      chk(rsp_valid && rsp_hit && !lk_stall && !req_valid, {lbl, " R2 main hit flags"},
          {rsp_valid, rsp_hit, lk_stall, req_valid}, 4'b1100);
      chk(rsp_data == exp, {lbl, " R2 main hit data"}, rsp_data, exp);
    end else begin
      e = find_vic(line);
      if (e >= 0) begin
        chk(lk_stall && !rsp_valid && !req_valid, {lbl, " R3 swap cycle 1"},
            {lk_stall, rsp_valid, req_valid}, 3'b100);
        lk_valid = 1'b1;
        lk_line  = line ^ 16'h0040;
        @(negedge clk);
        chk(lk_stall && !rsp_valid, {lbl, " R3 swap cycle 2"}, {lk_stall, rsp_valid}, 2'b10);
        lk_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid && rsp_hit && !lk_stall, {lbl, " R3 swap done"},
            {rsp_valid, rsp_hit, lk_stall}, 3'b110);
        chk(rsp_data == exp, {lbl, " R3 swap data"}, rsp_data, exp);
        v_v[e]  = m_v[s];
        v_l[e]  = m_l[s];
        v_st[e] = ++stamp;
        m_v[s]  = 1'b1;
        m_l[s]  = line;
        @(negedge clk);
        chk(!rsp_valid && !req_valid && !lk_stall, {lbl, " R8 lookup during stall ignored"},
            {rsp_valid, req_valid, lk_stall}, 3'b000);
      end else begin
        chk(req_valid && req_line == line && lk_stall && !rsp_valid, {lbl, " R5 request raised"},
            {req_valid, lk_stall, rsp_valid, req_line}, {3'b110, line});
        repeat (1 + int'($urandom % 3)) begin
          @(negedge clk);
          chk(req_valid && req_line == line && lk_stall && !rsp_valid, {lbl, " R5 request held"},
              {req_valid, lk_stall, rsp_valid, req_line}, {3'b110, line});
        end
        fill_valid = 1'b1;
        fill_data  = exp;
        @(negedge clk);
        fill_valid = 1'b0;
        chk(rsp_valid && !rsp_hit && !req_valid && !lk_stall, {lbl, " R6 fill response"},
            {rsp_valid, rsp_hit, req_valid, lk_stall}, 4'b1000);
        chk(rsp_data == exp, {lbl, " R6 fill data"}, rsp_data, exp);
        if (m_v[s]) begin
          p = pick_slot();
          v_v[p]  = 1'b1;
          v_l[p]  = m_l[s];
          v_st[p] = ++stamp;
        end
        m_v[s] = 1'b1;
        m_l[s] = line;
      end
    end
  endtask

  task automatic stray_fill();
    fill_valid = 1'b1;
    fill_data  = 32'hDEAD_BEEF;
    @(negedge clk);
    fill_valid = 1'b0;
    chk(!rsp_valid && !req_valid && !lk_stall, "R8 fill while idle ignored",
        {rsp_valid, req_valid, lk_stall}, 3'b000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; lk_valid = 1'b0; lk_line = '0; fill_valid = 1'b0; fill_data = '0;
    for (int i = 0; i < 8; i++) begin m_v[i] = 1'b0; m_l[i] = '0; end
    for (int i = 0; i < 4; i++) begin v_v[i] = 1'b0; v_l[i] = '0; v_st[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!lk_stall && !rsp_valid && !req_valid, "R1 reset outputs",
        {lk_stall, rsp_valid, req_valid}, 3'b000);
    lookup(16'h0008, "R1 first access");
    lookup(16'h0008, "R2 repeat");
    lookup(16'h0010, "R9 same set other tag");
    lookup(16'h0008, "R3 exchange");
    lookup(16'h0008, "R4 moved into main");
    lookup(16'h0010, "R4 displaced line");
    stray_fill();
    lookup(16'h0018, "R7 fill empty");
    lookup(16'h0020, "R7 fill empty");
    lookup(16'h0028, "R7 fill empty");
    lookup(16'h0030, "R7 replace oldest");
    lookup(16'h0020, "R7 recent entry kept");
    lookup(16'h0008, "R7 oldest was replaced");
    for (int k = 0; k < 400; k++) begin
      lookup(16'((($urandom % 6) << 3) | ($urandom % 3)), "random");
      if (k % 50 == 7) stray_fill();
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule